// File: doc/BRIEF.md
# Configuration Port Output Sequencer

This block sits between a word FIFO that already holds checked configuration data and a configuration-port style write interface. Whenever the FIFO has a word and the port is not busy, the sequencer pops the word and presents it on the port data bus. In the same cycle it drives the active-low chip enable and the active-low write enable. A side output carries odd parity over the data bus, so that a downstream consumer can check the path. While the port signals busy, everything is frozen.

A global error input takes priority over all of this. Once it is seen, no further FIFO word is consumed. Instead the sequencer issues a fixed abort pattern on the strobes and then parks with both strobes inactive. In both outcomes a done output is raised at the end, gated by an external qualifier input. On the success path, done waits until the FIFO is empty, the last packet has been committed, and the port has stayed idle for a fixed drain interval. The FIFO storage and the port itself lie outside the block.

Top module: `cfg_port_sequencer`

## Requirements
- R1: `fifo_rd` is high only in cycles where `fifo_empty` is low.
- R2: Every word popped is presented exactly once as a write, in FIFO order. A write is a cycle in which `port_ce_n`=0, `port_we_n`=0 and `port_busy`=0, with the word on `port_data`.
- R3: Both strobes are active low. During and after reset `port_ce_n`=1, `port_we_n`=1, `done`=0 and `fifo_rd`=0, and `port_we_n` is never 0 while `port_ce_n` is 1.
- R4: `port_par` makes the count of ones in {`port_data`,`port_par`} odd; with `port_data`=0 it reads 1.
- R5: In a cycle where `port_busy` is high, `fifo_rd` is 0, and `port_data`, `port_ce_n` and `port_we_n` keep their values across the following clock edge.
- R6: From the cycle in which `err_in` is high (and `done` is not yet reached), `fifo_rd` stays 0 until reset.
- R7: The abort pattern starts the cycle after `err_in` is sampled. It holds `port_ce_n`=0 and `port_we_n`=1 for exactly 4 cycles, after which both strobes stay 1.
- R8: After the abort pattern ends, `done` rises in the first cycle with both strobes high.
- R9: On the success path, `done` rises after 8 consecutive clock edges with `fifo_empty`=1, `last_commit`=1 and `port_busy`=0. Any interruption restarts the count.
- R10: `done` is 0 whenever `done_qual` is 0, and follows `done_qual` in the same cycle once completion is reached.
- R11: Once completion is reached, `err_in` and new FIFO data have no effect: no read, strobes stay 1 and `done` stays 1.
- R12: An error seen while `port_busy` is high still starts the abort pattern on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_empty | input | 1 | FIFO holds no word |
| fifo_rdata | input | 32 | Head word of the FIFO (show-ahead) |
| fifo_rd | output | 1 | Pop the head word at this edge |
| port_busy | input | 1 | Port cannot take a write this cycle |
| err_in | input | 1 | Global error, persistent until reset |
| last_commit | input | 1 | Last packet has been committed to the FIFO |
| done_qual | input | 1 | External qualifier for done |
| port_ce_n | output | 1 | Active-low port enable |
| port_we_n | output | 1 | Active-low port write enable |
| port_data | output | 32 | Port write data |
| port_par | output | 1 | Odd parity over port_data |
| done | output | 1 | Operation complete |

## Verification
Words are streamed through the block in three patterns, with a scoreboard confirming order and parity each time. A continuous feed with the port always ready shows that single-cycle transfers neither drop nor repeat words. A gapped feed combined with pseudo-random busy shows that stalls from either side freeze the port without losing data. Errors are injected mid-stream, under busy, and after success; this separates correct abort priority and exact abort length from a sequencer that keeps draining or ignores busy. A drain interval broken by a single busy cycle shows whether the success count restarts rather than resuming.

// File: rtl/cfg_port_sequencer.sv
`timescale 1ns/1ps
module cfg_port_sequencer #(
  parameter int DW        = 32,
  parameter int ABORT_LEN = 4,
  parameter int DRAIN_LEN = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_rdata,
  output logic          fifo_rd,
  input  logic          port_busy,
  input  logic          err_in,
  input  logic          last_commit,
  input  logic          done_qual,
  output logic          port_ce_n,
  output logic          port_we_n,
  output logic [DW-1:0] port_data,
  output logic          port_par,
  output logic          done
);
  localparam int AW = $clog2(ABORT_LEN + 1);
  localparam int CW = $clog2(DRAIN_LEN + 1);

  typedef enum logic [1:0] {S_XFER, S_ABORT, S_FIN} st_t;
  st_t st;
  logic [AW-1:0] ab_cnt;
  logic [CW-1:0] dr_cnt;

  wire drain_ok = fifo_empty & last_commit & ~port_busy;

  assign fifo_rd  = (st == S_XFER) & ~err_in & ~port_busy & ~fifo_empty;
  assign port_par = ~^port_data;
  assign done     = (st == S_FIN) & done_qual;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_XFER;
      ab_cnt    <= '0;
      dr_cnt    <= '0;
      port_ce_n <= 1'b1;
      port_we_n <= 1'b1;
      port_data <= '0;
    end else begin
      case (st)
        S_XFER: begin
          if (err_in) begin
            st        <= S_ABORT;
            ab_cnt    <= '0;
            port_ce_n <= 1'b0;
            port_we_n <= 1'b1;
            port_data <= '0;
          end else begin
            if (!port_busy) begin
              if (!fifo_empty) begin
                port_ce_n <= 1'b0;
                port_we_n <= 1'b0;
                port_data <= fifo_rdata;
              end else begin
                port_ce_n <= 1'b1;
                port_we_n <= 1'b1;
              end
            end
            if (drain_ok) begin
              if (dr_cnt == CW'(DRAIN_LEN - 1)) st <= S_FIN;
              else dr_cnt <= dr_cnt + 1'b1;
            end else begin
              dr_cnt <= '0;
            end
          end
        end
        S_ABORT: begin
          if (ab_cnt == AW'(ABORT_LEN - 1)) begin
            st        <= S_FIN;
            port_ce_n <= 1'b1;
            port_we_n <= 1'b1;
          end else begin
            ab_cnt <= ab_cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_port_sequencer_chk.sv
`timescale 1ns/1ps
module cfg_port_sequencer_chk #(
  parameter int DW        = 32,
  parameter int ABORT_LEN = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          fifo_empty,
  input logic          fifo_rd,
  input logic          port_busy,
  input logic          err_in,
  input logic          port_ce_n,
  input logic          port_we_n,
  input logic [DW-1:0] port_data,
  input logic          done,
  input logic          done_qual,
  input logic [1:0]    st_q
);
  logic       err_seen;
  logic [7:0] ab_run;
  wire in_xfer = (st_q == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_seen <= 1'b0;
      ab_run   <= '0;
    end else begin
      if (err_in && in_xfer) err_seen <= 1'b1;
      if (!port_ce_n && port_we_n) ab_run <= ab_run + 1'b1;
      else ab_run <= '0;
    end
  end

  // R1
  rd_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty);
  // R5
  rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    port_busy |-> !fifo_rd);
  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && port_busy && !err_in) |=>
      ($stable(port_data) && $stable(port_ce_n) && $stable(port_we_n)));
  // R6
  err_no_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_seen || err_in) |-> !fifo_rd);
  // R7
  abort_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ab_run <= 8'(ABORT_LEN));
  // R3
  strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_we_n |-> !port_ce_n);
  // R10
  done_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_qual);
  // R11
  done_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(done) && done_qual) |-> done);
endmodule

bind cfg_port_sequencer cfg_port_sequencer_chk #(.DW(DW), .ABORT_LEN(ABORT_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_rd(fifo_rd),
  .port_busy(port_busy), .err_in(err_in), .port_ce_n(port_ce_n),
  .port_we_n(port_we_n), .port_data(port_data), .done(done),
  .done_qual(done_qual), .st_q(st)
);

// File: tb/tb_cfg_port_sequencer.sv
`timescale 1ns/1ps
module tb_cfg_port_sequencer;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        fifo_empty = 1;
  logic [31:0] fifo_rdata = '0;
  logic        fifo_rd;
  logic        port_busy = 0;
  logic        err_in = 0;
  logic        last_commit = 0;
  logic        done_qual = 1;
  logic        port_ce_n, port_we_n, port_par, done;
  logic [31:0] port_data;

  always #10 clk = ~clk;

  cfg_port_sequencer dut (
    .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_rdata(fifo_rdata),
    .fifo_rd(fifo_rd), .port_busy(port_busy), .err_in(err_in),
    .last_commit(last_commit), .done_qual(done_qual), .port_ce_n(port_ce_n),
    .port_we_n(port_we_n), .port_data(port_data), .port_par(port_par), .done(done)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] src_q[$], fifo_q[$], exp_q[$];
  int   feed_gap = 0, cyc = 0;
  bit   busy_rand = 0, sb_on = 1, hold_on = 0, rd_seen = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic        p_busy = 0, p_ce = 1, p_we = 1;
  logic [31:0] p_data = '0;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) rd_seen <= fifo_rd & rst_n;

  always @(negedge clk) begin
    if (rd_seen) void'(fifo_q.pop_front());
    cyc++;
    if (src_q.size() > 0 && (cyc % (feed_gap + 1)) == 0) fifo_q.push_back(src_q.pop_front());
    fifo_empty = (fifo_q.size() == 0);
    fifo_rdata = fifo_empty ? 32'h0 : fifo_q[0];
    if (busy_rand) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      port_busy = lfsr[0] & lfsr[3];
    end
  end

  always @(negedge clk) begin
    #1;
    if (rst_n && sb_on) begin
      if (!port_ce_n && !port_we_n && !port_busy) begin
        if (exp_q.size() == 0) chk(0, "R2 unexpected write", port_data, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(port_data == e, "R2 write order", port_data, e);
          chk(port_par == ~^e, "R4 odd parity", port_par, ~^e);
        end
      end
      if (fifo_rd) chk(!fifo_empty, "R1 read only when non-empty", fifo_empty, 0);
      if (port_busy) chk(!fifo_rd, "R5 no pop while busy", fifo_rd, 0);
      if (hold_on && p_busy)
        chk(port_data == p_data && port_ce_n == p_ce && port_we_n == p_we,
            "R5 hold while busy", {port_ce_n, port_we_n, port_data}, {p_ce, p_we, p_data});
    end
    p_busy = port_busy & rst_n;
    p_ce = port_ce_n; p_we = port_we_n; p_data = port_data;
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; err_in = 0; port_busy = 0; busy_rand = 0; last_commit = 0;
    done_qual = 1; feed_gap = 0; sb_on = 1; hold_on = 0;
    src_q.delete(); fifo_q.delete(); exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic send(int n, int seed, bit expect_it);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      if (i == 1) w = 32'h0;
      else if (i == 2) w = 32'hFFFF_FFFF;
      else w = {8'(seed), 8'(i), 8'(i * 7 + 3), 8'(~i)};
      src_q.push_back(w);
      if (expect_it) exp_q.push_back(w);
    end
  endtask

  task automatic wait_drain();
    while (exp_q.size() > 0 || src_q.size() > 0 || fifo_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_abort(string tag);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk); #2;
      chk(port_ce_n == 0 && port_we_n == 1, {tag, " R7 abort pattern"}, {port_ce_n, port_we_n}, 2'b01);
      chk(!fifo_rd, {tag, " R6 no pop after error"}, fifo_rd, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // reset state
    repeat (2) @(negedge clk); #2;
    chk(port_ce_n && port_we_n, "R3 strobes idle in reset", {port_ce_n, port_we_n}, 2'b11);
    chk(!done, "R3 done low in reset", done, 0);
    chk(!fifo_rd, "R3 no pop in reset", fifo_rd, 0);
    chk(port_par == 1'b1, "R4 parity of zero bus", port_par, 1);
    do_reset();

    // continuous stream, then success drain
    hold_on = 1;
    send(6, 1, 1);
    wait_drain();
    chk(exp_q.size() == 0, "R2 all words written", exp_q.size(), 0);
    chk(!done, "R9 no done before commit", done, 0);
    last_commit = 1;
    repeat (7) @(negedge clk); #2;
    chk(!done, "R9 done not before 8 cycles", done, 0);
    @(negedge clk); #2;
    chk(done, "R9 done after 8 idle cycles", done, 1);

    // gapped feed with random busy
    do_reset();
    hold_on = 1; feed_gap = 2; busy_rand = 1;
    send(40, 2, 1);
    wait_drain();
    busy_rand = 0; port_busy = 0;
    chk(exp_q.size() == 0, "R2 gapped and stalled stream complete", exp_q.size(), 0);

    // drain interrupted by busy restarts, and qualifier gating
    do_reset();
    last_commit = 1;
    repeat (5) @(negedge clk);
    port_busy = 1;
    @(negedge clk);
    port_busy = 0; #2;
    chk(!done, "R9 done low after interruption", done, 0);
    @(negedge clk);
    repeat (6) @(negedge clk); #2;
    chk(!done, "R9 count restarted after busy", done, 0);
    @(negedge clk); #2;
    chk(done, "R9 done after restarted drain", done, 1);
    done_qual = 0; #1;
    chk(!done, "R10 done gated low by qualifier", done, 0);
    done_qual = 1; #1;
    chk(done, "R10 done follows qualifier", done, 1);

    // error mid-stream
    do_reset();
    send(20, 3, 1);
    do @(negedge clk); while (exp_q.size() > 14);
    err_in = 1; #2;
    chk(!fifo_rd, "R6 no pop in error cycle", fifo_rd, 0);
    check_abort("mid-stream");
    @(negedge clk); #2;
    chk(port_ce_n && port_we_n, "R7 strobes high after abort", {port_ce_n, port_we_n}, 2'b11);
    chk(done, "R8 done after abort", done, 1);
    sb_on = 0;
    repeat (6) @(negedge clk); #2;
    chk(port_ce_n && port_we_n && !fifo_rd, "R7 strobes stay high", {port_ce_n, port_we_n, fifo_rd}, 3'b110);
    chk(fifo_q.size() > 0 && !fifo_empty, "R6 FIFO left undrained", fifo_q.size(), 1);

    // error while busy, qualifier low at the end
    do_reset();
    sb_on = 0;
    port_busy = 1;
    send(5, 4, 0);
    repeat (4) @(negedge clk);
    err_in = 1;
    check_abort("under busy R12");
    done_qual = 0;
    @(negedge clk); #2;
    chk(port_ce_n && port_we_n, "R12 abort ends under busy", {port_ce_n, port_we_n}, 2'b11);
    chk(!done, "R10 done held by qualifier after abort", done, 0);
    done_qual = 1; #1;
    chk(done, "R8 done after abort with qualifier", done, 1);

    // error and data after success
    do_reset();
    sb_on = 0;
    last_commit = 1;
    repeat (10) @(negedge clk); #2;
    chk(done, "R11 success reached", done, 1);
    @(negedge clk);
    err_in = 1;
    send(3, 5, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); #2;
      chk(done && port_ce_n && port_we_n && !fifo_rd, "R11 completion unaffected",
          {done, port_ce_n, port_we_n, fifo_rd}, 4'b1110);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule